// File: doc/BRIEF.md
# Single-Channel Block Transfer DMA Engine

This engine moves one block of bytes between a single device port and memory while the processor does other work. Software sets up four registers: the first memory address, the number of bytes, the device address and a control word. Writing the control word with the start bit set launches the block. The engine then fetches each byte from its source and stores it at its destination, one byte at a time, until the count runs out.

Two directions are supported. In device-to-memory mode the engine accepts bytes from the device through a ready/valid handshake and writes them to memory. In memory-to-device mode it reads bytes from memory and offers them to the device. Every memory access is a request that is held until the memory grants it. When the last byte lands, the engine sets a done flag and, if enabled, raises an interrupt. Software then either programs and starts another block or leaves the engine idle.

Top module: `blk_dma`

## Requirements
- R1: The register offsets are 0 = memory address, 1 = byte count, 2 = device address and 3 = control/status. In a control write, bit 0 = start, bit 1 = direction (1 = memory to device) and bit 2 = interrupt enable. A status read gives bit 7 = busy, bit 6 = done, bit 2 = interrupt enable and bit 1 = direction, with all other bits 0. After reset every register reads 0. `dev_addr` always shows the programmed device address.
- R2: In device-to-memory mode, each byte accepted from the device (`dev_rd_valid` and `dev_rd_ready` both high) is then written to memory at the current address, with `mem_we` = 1, `mem_req` = 1 and `mem_wdata` equal to that byte.
- R3: In memory-to-device mode, each byte read from memory (`mem_req` with `mem_we` = 0 and `mem_gnt`, data taken from `mem_rdata` in that cycle) is then offered on `dev_wr_data` with `dev_wr_valid` = 1.
- R4: Each completed byte adds one to the memory address and subtracts one from the count. A byte completes on the memory grant of a write, or on `dev_wr_ready` for a device write.
- R5: Done is set and busy is cleared at the same clock edge at which the count reaches zero.
- R6: While busy, a start command and writes to offsets 0, 1 and 2 are ignored.
- R7: A start with a count of zero sets done at the next edge. It issues no memory request and does not set busy.
- R8: `irq` is high whenever done and the interrupt enable are both set. It stays high until software writes control with bit 6 = 1, which clears done. A done that is being set wins over a clear in the same cycle.
- R9: A memory request holds its address and data until it is granted. A device write offer holds its data until the device is ready.
- R10: After done, software can program and start a new block. A single control write can both clear done and start the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Current memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_gnt | input | 1 | Memory grant |
| mem_rdata | input | 8 | Memory read byte, valid with grant |
| dev_addr | output | DEV_W | Programmed device address |
| dev_rd_valid | input | 1 | Device has a byte |
| dev_rd_data | input | 8 | Byte from device |
| dev_rd_ready | output | 1 | Engine accepts a device byte |
| dev_wr_valid | output | 1 | Engine offers a byte to the device |
| dev_wr_data | output | 8 | Byte to device |
| dev_wr_ready | input | 1 | Device accepts the byte |
| irq | output | 1 | Done interrupt |

## Verification
The outputs `mem_req`, `mem_we`, `dev_rd_ready`, `dev_wr_valid`, `mem_addr`, `dev_addr` and `irq` change one edge after the handshake or register write that causes them. A status or count read reflects a write or a final handshake from the next edge onwards. The bench keeps a behavioural model that applies the same edge. It compares every output at the falling edge after each rising edge, and it checks write data in the very cycle that the model expects the handshake. Register reads are sampled shortly after the read offset is driven, because the read path is combinational.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic {PH_FETCH = 1'b0, PH_STORE = 1'b1} phase_t;

  localparam logic [1:0] OFS_MADDR = 2'd0;
  localparam logic [1:0] OFS_COUNT = 2'd1;
  localparam logic [1:0] OFS_DEV   = 2'd2;
  localparam logic [1:0] OFS_CTRL  = 2'd3;

  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_IE    = 2;
  localparam int ST_DONE   = 6;
  localparam int ST_BUSY   = 7;

  function automatic logic [7:0] pack_status(input logic busy, input logic done,
                                             input logic ie, input logic dir);
    logic [7:0] s;
    s = '0;
    s[ST_BUSY] = busy;
    s[ST_DONE] = done;
    s[CTL_IE]  = ie;
    s[CTL_DIR] = dir;
    return s;
  endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic [DEV_W-1:0]  dev_addr,
  output logic              busy,
  output logic              done,
  output logic              dir,
  output logic              ie,
  output logic              start_accept,
  output logic              last_step,
  output logic              done_clr
);
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c);
    return c - 1'b1;
  endfunction

  logic ctl_wr, wr_maddr, wr_count, wr_dev, zero_start;

  assign ctl_wr       = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_maddr     = reg_wr && (reg_addr == OFS_MADDR) && !busy;
  assign wr_count     = reg_wr && (reg_addr == OFS_COUNT) && !busy;
  assign wr_dev       = reg_wr && (reg_addr == OFS_DEV) && !busy;
  assign start_accept = ctl_wr && reg_wdata[CTL_START] && !busy;
  assign zero_start   = start_accept && (cur_count == '0);
  assign last_step    = step && (cur_count == CNT_W'(1));
  assign done_clr     = ctl_wr && reg_wdata[ST_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_count <= '0;
      dev_addr  <= '0;
      dir       <= 1'b0;
      ie        <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (wr_maddr)  cur_addr <= reg_wdata[ADDR_W-1:0];
      else if (step) cur_addr <= addr_next(cur_addr);

      if (wr_count)  cur_count <= reg_wdata[CNT_W-1:0];
      else if (step) cur_count <= count_next(cur_count);

      if (wr_dev) dev_addr <= reg_wdata[DEV_W-1:0];

      if (ctl_wr && !busy) begin
        dir <= reg_wdata[CTL_DIR];
        ie  <= reg_wdata[CTL_IE];
      end

      if (start_accept && !zero_start) busy <= 1'b1;
      else if (last_step)              busy <= 1'b0;

      if (last_step || zero_start) done <= 1'b1;
      else if (done_clr)           done <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_MADDR: reg_rdata = REG_W'(cur_addr);
      OFS_COUNT: reg_rdata = REG_W'(cur_count);
      OFS_DEV:   reg_rdata = REG_W'(dev_addr);
      default:   reg_rdata = REG_W'(pack_status(busy, done, ie, dir));
    endcase
  end
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              dir,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_rd_valid,
  input  logic [DATA_W-1:0] dev_rd_data,
  input  logic              dev_wr_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              dev_rd_ready,
  output logic              dev_wr_valid,
  output logic [DATA_W-1:0] dev_wr_data,
  output logic              step
);
  phase_t            phase;
  logic [DATA_W-1:0] buf_q;
  logic              fetching, storing, fetch_hs, store_hs;

  assign fetching = busy && (phase == PH_FETCH);
  assign storing  = busy && (phase == PH_STORE);

  assign mem_req      = dir ? fetching : storing;
  assign mem_we       = storing && !dir;
  assign dev_rd_ready = fetching && !dir;
  assign dev_wr_valid = storing && dir;
  assign mem_wdata    = buf_q;
  assign dev_wr_data  = buf_q;

  assign fetch_hs = fetching && (dir ? mem_gnt : dev_rd_valid);
  assign store_hs = storing && (dir ? dev_wr_ready : mem_gnt);
  assign step     = store_hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
      buf_q <= '0;
    end else begin
      if (!busy || store_hs) phase <= PH_FETCH;
      else if (fetch_hs)     phase <= PH_STORE;
      if (fetch_hs) buf_q <= dir ? mem_rdata : dev_rd_data;
    end
  end
endmodule

// File: rtl/blk_dma.sv
module blk_dma
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8,
  localparam int MAX_AC = (ADDR_W > CNT_W) ? ADDR_W : CNT_W,
  localparam int MAX_AD = (MAX_AC > DEV_W) ? MAX_AC : DEV_W,
  localparam int REG_W  = (MAX_AD > 8) ? MAX_AD : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic [DEV_W-1:0]  dev_addr,
  input  logic              dev_rd_valid,
  input  logic [7:0]        dev_rd_data,
  output logic              dev_rd_ready,
  output logic              dev_wr_valid,
  output logic [7:0]        dev_wr_data,
  input  logic              dev_wr_ready,
  output logic              irq
);
  logic             busy_w, done_w, dir_w, ie_w;
  logic             step_w, start_acc_w, last_step_w, done_clr_w;
  logic [CNT_W-1:0] count_w;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step(step_w),
    .cur_addr(mem_addr), .cur_count(count_w), .dev_addr(dev_addr),
    .busy(busy_w), .done(done_w), .dir(dir_w), .ie(ie_w),
    .start_accept(start_acc_w), .last_step(last_step_w), .done_clr(done_clr_w)
  );

  dma_mover #(.DATA_W(8)) u_mover (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .dir(dir_w),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data),
    .dev_wr_ready(dev_wr_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .dev_rd_ready(dev_rd_ready),
    .dev_wr_valid(dev_wr_valid), .dev_wr_data(dev_wr_data), .step(step_w)
  );

  assign irq = done_w && ie_w;
endmodule

// File: rtl/blk_dma_chk.sv
module blk_dma_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              dev_wr_valid,
  input logic              dev_wr_ready,
  input logic [7:0]        dev_wr_data,
  input logic              irq,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  count,
  input logic              step,
  input logic              start_accept,
  input logic              last_step,
  input logic              done_clr
);
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == CNT_W'($past(count) - 1'b1));

  a_r5_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done && !busy && (count == '0));

  a_r6_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> $stable(mem_addr) && $stable(count));

  a_r7_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_accept && count == '0) |=> done && !busy && !mem_req);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !done_clr) |=> irq);

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  a_r9_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr_valid && !dev_wr_ready) |=> dev_wr_valid && $stable(dev_wr_data));
endmodule

bind blk_dma blk_dma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dev_wr_valid(dev_wr_valid),
  .dev_wr_ready(dev_wr_ready), .dev_wr_data(dev_wr_data), .irq(irq),
  .busy(busy_w), .done(done_w), .count(count_w), .step(step_w),
  .start_accept(start_acc_w), .last_step(last_step_w), .done_clr(done_clr_w)
);

// File: tb/blk_dma_tb.sv
`timescale 1ns/1ps
module blk_dma_tb;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int RW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, reg_wr, mem_req, mem_we, mem_gnt, dev_rd_valid, dev_rd_ready;
  logic dev_wr_valid, dev_wr_ready, irq;
  logic [1:0]    reg_addr;
  logic [RW-1:0] reg_wdata, reg_rdata;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata, dev_rd_data, dev_wr_data;
  logic [DW-1:0] dev_addr;

  logic [7:0] bmem [256];
  logic [7:0] sink [$];
  int src_idx = 0;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit m_busy, m_phase, m_done, m_ie, m_dir;
  int m_addr, m_cnt, m_dev;
  logic [7:0] m_buf;

  function automatic logic [7:0] src_byte(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  assign mem_rdata   = bmem[mem_addr[7:0]];
  assign dev_rd_data = src_byte(src_idx);

  blk_dma #(.ADDR_W(AW), .CNT_W(CW), .DEV_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .dev_addr(dev_addr),
    .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data),
    .dev_rd_ready(dev_rd_ready), .dev_wr_valid(dev_wr_valid),
    .dev_wr_data(dev_wr_data), .dev_wr_ready(dev_wr_ready), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: entered at a falling edge, left at the next falling edge
  task automatic tick();
    bit exp_req, fetch_hs, store_hs, mem_upd, src_inc;
    bit n_busy, n_phase, n_done, n_ie, n_dir;
    int n_addr, n_cnt, n_dev, upd_addr;
    logic [7:0] n_buf, upd_val;
    mem_gnt      = (cyc % 3) != 2;
    dev_rd_valid = (cyc % 5) != 0;
    dev_wr_ready = (cyc % 4) != 3;
    #0.5;
    exp_req = m_busy && (m_dir ? !m_phase : m_phase);
    chk("R2", "mem_req", 32'(mem_req), 32'(exp_req));
    chk("R4", "mem_addr", 32'(mem_addr), 32'(m_addr));
    chk("R2", "dev_rd_ready", 32'(dev_rd_ready), 32'(m_busy && !m_dir && !m_phase));
    chk("R3", "dev_wr_valid", 32'(dev_wr_valid), 32'(m_busy && m_dir && m_phase));
    chk("R8", "irq", 32'(irq), 32'(m_done && m_ie));
    chk("R1", "dev_addr", 32'(dev_addr), 32'(m_dev));
    if (exp_req) chk("R2", "mem_we", 32'(mem_we), 32'(!m_dir));

    n_busy = m_busy; n_phase = m_phase; n_done = m_done; n_ie = m_ie; n_dir = m_dir;
    n_addr = m_addr; n_cnt = m_cnt; n_dev = m_dev; n_buf = m_buf;
    mem_upd = 0; src_inc = 0; upd_addr = 0; upd_val = '0;
    fetch_hs = m_busy && !m_phase && (m_dir ? mem_gnt : dev_rd_valid);
    store_hs = m_busy && m_phase && (m_dir ? dev_wr_ready : mem_gnt);
    if (fetch_hs) begin
      n_phase = 1;
      if (m_dir) n_buf = bmem[m_addr & 255];
      else begin n_buf = src_byte(src_idx); src_inc = 1; end
    end
    if (store_hs) begin
      if (!m_dir) begin
        chk("R2", "mem_wdata", 32'(mem_wdata), 32'(m_buf));
        mem_upd = 1; upd_addr = m_addr & 255; upd_val = m_buf;
      end else begin
        chk("R3", "dev_wr_data", 32'(dev_wr_data), 32'(m_buf));
        sink.push_back(m_buf);
      end
      n_phase = 0;
      n_addr = (m_addr + 1) & 16'hFFFF;
      n_cnt  = (m_cnt - 1) & 16'hFFFF;
    end
    if (reg_wr) begin
      if (!m_busy && reg_addr == 2'd0) n_addr = reg_wdata;
      if (!m_busy && reg_addr == 2'd1) n_cnt = reg_wdata;
      if (!m_busy && reg_addr == 2'd2) n_dev = reg_wdata[7:0];
      if (reg_addr == 2'd3) begin
        if (reg_wdata[6]) n_done = 0;
        if (!m_busy) begin
          n_dir = reg_wdata[1];
          n_ie  = reg_wdata[2];
          if (reg_wdata[0]) begin
            if (m_cnt == 0) n_done = 1;
            else begin n_busy = 1; n_phase = 0; end
          end
        end
      end
    end
    if (store_hs && m_cnt == 1) begin n_busy = 0; n_done = 1; end

    @(posedge clk);
    #1;
    m_busy = n_busy; m_phase = n_phase; m_done = n_done; m_ie = n_ie; m_dir = n_dir;
    m_addr = n_addr; m_cnt = n_cnt; m_dev = n_dev; m_buf = n_buf;
    if (mem_upd) bmem[upd_addr] = upd_val;
    if (src_inc) src_idx++;
    cyc++;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [RW-1:0] exp,
                    input string req, input string what);
    reg_addr = a;
    #0.3;
    chk(req, what, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic run(input string req);
    int n;
    n = 0;
    while (m_busy && n < 500) begin tick(); n++; end
    chk(req, "block finished in time", 32'(m_busy), 32'd0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'(i ^ 8'hC3);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_gnt = 1'b0; dev_rd_valid = 1'b0; dev_wr_ready = 1'b0;
    m_busy = 0; m_phase = 0; m_done = 0; m_ie = 0; m_dir = 0;
    m_addr = 0; m_cnt = 0; m_dev = 0; m_buf = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) rd(2'(a), '0, "R1", "reset register");
    chk("R1", "reset irq", 32'(irq), 32'd0);
    chk("R1", "reset mem_req", 32'(mem_req), 32'd0);

    // R2 device to memory, 5 bytes at 0x10, irq enabled
    wr(2'd0, 16'h0010); wr(2'd1, 16'd5); wr(2'd2, 16'h003C);
    chk("R1", "dev_addr programmed", 32'(dev_addr), 32'h3C);
    rd(2'd3, 16'h0000, "R1", "status idle before start");
    wr(2'd3, 16'h0005);
    rd(2'd3, 16'h0084, "R1", "status busy with enable");
    run("R2");
    rd(2'd3, 16'h0044, "R5", "status done, not busy");
    rd(2'd1, 16'd0, "R5", "count reached zero");
    rd(2'd0, 16'h0015, "R4", "address advanced by count");
    for (int i = 0; i < 5; i++)
      chk("R2", "memory byte", 32'(bmem[16 + i]), 32'(src_byte(i)));

    // R8 irq holds until done is cleared
    repeat (7) tick();
    chk("R8", "irq held", 32'(irq), 32'd1);
    wr(2'd3, 16'h0044);
    chk("R8", "irq cleared by done write", 32'(irq), 32'd0);
    rd(2'd3, 16'h0004, "R8", "done cleared, enable kept");

    // R3 memory to device, with R6 ignored writes while busy
    wr(2'd0, 16'h0010); wr(2'd1, 16'd5); wr(2'd3, 16'h0003);
    tick(); tick();
    wr(2'd3, 16'h0007);
    wr(2'd0, 16'h0080);
    wr(2'd1, 16'h0020);
    wr(2'd2, 16'h0055);
    chk("R6", "device address kept while busy", 32'(dev_addr), 32'h3C);
    run("R3");
    chk("R3", "bytes delivered", 32'(sink.size()), 32'd5);
    for (int i = 0; i < sink.size(); i++)
      chk("R3", "device byte", 32'(sink[i]), 32'(src_byte(i)));
    rd(2'd1, 16'd0, "R6", "count write while busy ignored");
    rd(2'd0, 16'h0015, "R6", "address write while busy ignored");
    rd(2'd3, 16'h0042, "R6", "second start ignored, enable unchanged");

    // R7 zero-count start
    wr(2'd3, 16'h0040);
    rd(2'd3, 16'h0000, "R7", "done cleared before zero start");
    wr(2'd3, 16'h0001);
    rd(2'd3, 16'h0040, "R7", "zero start sets done, not busy");
    chk("R7", "no memory request", 32'(mem_req), 32'd0);
    tick();
    rd(2'd0, 16'h0015, "R7", "address untouched");

    // R10 chain: clear done and start the next block in one write
    wr(2'd0, 16'h0040); wr(2'd1, 16'd3);
    wr(2'd3, 16'h0045);
    rd(2'd3, 16'h0084, "R10", "done cleared and busy in one write");
    run("R10");
    for (int i = 0; i < 3; i++)
      chk("R10", "chained memory byte", 32'(bmem[64 + i]), 32'(src_byte(5 + i)));
    rd(2'd3, 16'h0044, "R10", "chained block done");
    chk("R8", "irq after chained block", 32'(irq), 32'd1);

    repeat (3) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule